// File: doc/BRIEF.md
# Framed Synchronous Serial Port

This block is a full-duplex, word-oriented serial port. The transmit path and the receive path are separate. Each has its own bit clock, its own frame-sync line and its own data line. A frame starts on a falling frame-sync edge. Every word is 16 bits long and travels most significant bit first. Data changes on a rising bit-clock edge and is sampled on a falling bit-clock edge.

The receive path always takes its bit clock from outside. Once it sees the receive frame sync fall, it shifts bits from the serial input into a receive shifter. A finished word moves into a receive holding register, and the block flags that it is ready. If a second word completes before the first is read, an overrun flag is set.

The transmit path takes words from a transmit holding register. Two control bits set how it runs:
- The clock-mode bit chooses between an external bit clock and one the port generates at half the system clock.
- The frame-mode bit chooses between an external frame sync and a one-bit-wide active-low pulse the port generates.

An active-low disable input tri-states every pin the port can drive. All external clock, frame and data inputs pass through two-flop synchronizers into the system clock domain, and edges are detected after synchronization.

Top module: `fsp_port`

## Requirements
- R1: After synchronous reset both control bits read 0, `tclk_oe` and `tfs_oe` are 0, `tfs_out` is 1, `tx_empty` is 1, and `rx_ready` and `rx_overrun` are 0.
- R2: A write with `ctl_we` stores `ctl_wdata[0]` (clock master) and `ctl_wdata[1]` (frame master), and they read back on `ctl_rdata[1:0]` on the next cycle. `ctl_rdata[2]` follows the level on `rclk_in` within three system cycles.
- R3: With the clock-master bit set, `tclk_out` inverts on every system clock edge, giving half the system rate, and `tclk_oe` is 1 while `hiz_n` is 1.
- R4: With the frame-master bit set, `tfs_out` goes low only while a word waits in the holding register and the shifter is idle. The low pulse lasts exactly one transmit bit period, which is two system cycles under the internal clock, and it starts together with the first data bit.
- R5: A transmit frame drives the 16 bits of the word on `sdo`, most significant bit first. The first bit is driven as the frame starts, and each later bit on a rising transmit bit-clock edge. In slave frame mode, a falling edge on `tfs_in` starts the frame.
- R6: After a falling edge on `rfs_in`, the next 16 falling edges of `rclk_in` sample `sdi`, most significant bit first. The word then appears on `rx_data`, and `rx_ready` rises.
- R7: If a word completes while `rx_ready` is still 1, `rx_overrun` becomes 1 and `rx_data` takes the newer word.
- R8: A one-cycle `rx_read` pulse clears both `rx_ready` and `rx_overrun`.
- R9: While `hiz_n` is 0, `sdo_oe`, `tclk_oe` and `tfs_oe` are all 0.
- R10: `tx_load` fills the holding register, so `tx_empty` becomes 0. The start of a frame moves the word into the shifter, so `tx_empty` becomes 1. A frame started with an empty holding register sends the last loaded word again.
- R11: Edges on `rclk_in` while no frame has begun leave the receiver untouched: `rx_ready` stays 0 and the next framed word arrives intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 0 clock master, bit 1 frame master |
| ctl_rdata | output | 3 | Control bits, plus bit 2 = synchronized receive clock level |
| tx_load | input | 1 | Write `tx_data` into the transmit holding register |
| tx_data | input | 16 | Word to transmit |
| tx_empty | output | 1 | Transmit holding register is empty |
| rx_read | input | 1 | Acknowledge the received word |
| rx_data | output | 16 | Receive holding register |
| rx_ready | output | 1 | Unread word present |
| rx_overrun | output | 1 | A word was overwritten before being read |
| hiz_n | input | 1 | Active-low output disable |
| tclk_in | input | 1 | External transmit bit clock |
| tclk_out | output | 1 | Generated transmit bit clock |
| tclk_oe | output | 1 | Transmit clock output enable |
| tfs_in | input | 1 | External transmit frame sync |
| tfs_out | output | 1 | Generated transmit frame sync, active low |
| tfs_oe | output | 1 | Transmit frame sync output enable |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| rclk_in | input | 1 | Receive bit clock |
| rfs_in | input | 1 | Receive frame sync |
| sdi | input | 1 | Serial data in |

## Verification
The assertions assume several things about the inputs:
- The control bits do not change while a frame is in flight.
- External clock, frame and data inputs change together, so they stay aligned after the equal-depth synchronizers.
- Each external bit-clock half period is long compared with the synchronizer latency.

The stimulus keeps within these limits. It writes the mode only between frames. It drives every slave-side pin from the same #1-after-edge point, with five-cycle half periods. It changes receive data and frame sync only on its own rising clock edges. Master-mode traffic is looped back from the transmit pins into the receiver, which exercises both paths at the fastest bit rate.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    parameter int FSP_WORD_W = 16;

    // index of each external pin inside the synchronizer bundle
    localparam int PIN_TCLK = 0;
    localparam int PIN_TFS  = 1;
    localparam int PIN_RCLK = 2;
    localparam int PIN_RFS  = 3;
    localparam int PIN_SDI  = 4;
    localparam int PIN_N    = 5;

    // idle levels: frame syncs rest high, clocks and data low
    localparam logic [PIN_N-1:0] PIN_IDLE = 5'b01010;

    typedef struct packed {
        logic fs_master;
        logic clk_master;
    } fsp_ctrl_t;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_SHIFT = 1'b1
    } fsp_phase_e;

    function automatic int fsp_cnt_w(input int w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/fsp_sync.sv
module fsp_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx
    import fsp_pkg::*;
#(
    parameter int W = FSP_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  fsp_ctrl_t    ctrl,
    input  logic         xclk_s,
    input  logic         xfs_s,
    input  logic         load,
    input  logic [W-1:0] load_data,
    output logic         empty,
    output logic         bclk_gen,
    output logic         fs_gen,
    output logic         sdo
);
    localparam int CW = fsp_cnt_w(W);

    logic         clkgen_q, xclk_prev, xfs_prev;
    logic [W-1:0] hold_q, shreg_q;
    logic         full_q;
    logic [CW-1:0] cnt_q;
    fsp_phase_e   phase_q;
    logic         bit_rise, ext_start, int_start, start;

    // master clock: next edge drives clkgen high when it is low now
    assign bit_rise  = ctrl.clk_master ? ~clkgen_q : (xclk_s & ~xclk_prev);
    assign ext_start = ~ctrl.fs_master & ~xfs_s & xfs_prev;
    assign int_start = ctrl.fs_master & bit_rise & full_q;
    assign start     = (phase_q == PH_IDLE) & (ext_start | int_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            clkgen_q  <= 1'b0;
            xclk_prev <= 1'b0;
            xfs_prev  <= 1'b1;
        end else begin
            clkgen_q  <= ctrl.clk_master ? ~clkgen_q : 1'b0;
            xclk_prev <= xclk_s;
            xfs_prev  <= xfs_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (load) hold_q <= load_data;
            full_q <= load | (full_q & ~start);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            sdo     <= 1'b0;
        end else if (start) begin
            phase_q <= PH_SHIFT;
            sdo     <= hold_q[W-1];
            shreg_q <= {hold_q[W-2:0], 1'b0};
            cnt_q   <= CW'(1);
        end else if (phase_q == PH_SHIFT && bit_rise) begin
            if (cnt_q == CW'(W)) begin
                phase_q <= PH_IDLE;
                sdo     <= 1'b0;
            end else begin
                sdo     <= shreg_q[W-1];
                shreg_q <= {shreg_q[W-2:0], 1'b0};
                cnt_q   <= cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            fs_gen <= 1'b1;
        else if (start && int_start) fs_gen <= 1'b0;
        else if (bit_rise)  fs_gen <= 1'b1;
    end

    assign empty    = ~full_q;
    assign bclk_gen = clkgen_q;
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx
    import fsp_pkg::*;
#(
    parameter int W = FSP_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rclk_s,
    input  logic         rfs_s,
    input  logic         sdi_s,
    input  logic         rd,
    output logic [W-1:0] word,
    output logic         ready,
    output logic         overrun
);
    localparam int CW = fsp_cnt_w(W);

    logic           rclk_prev, rfs_prev;
    logic [W-2:0]   shreg_q;
    logic [CW-1:0]  cnt_q;
    fsp_phase_e     phase_q;
    logic           bit_fall, fs_fall, done;

    assign bit_fall = ~rclk_s & rclk_prev;
    assign fs_fall  = ~rfs_s & rfs_prev;
    assign done     = (phase_q == PH_SHIFT) & bit_fall & (cnt_q == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rclk_prev <= 1'b0;
            rfs_prev  <= 1'b1;
        end else begin
            rclk_prev <= rclk_s;
            rfs_prev  <= rfs_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            if (fs_fall) begin
                phase_q <= PH_SHIFT;
                cnt_q   <= '0;
            end
        end else if (bit_fall) begin
            shreg_q <= {shreg_q[W-3:0], sdi_s};
            if (done) phase_q <= PH_IDLE;
            else      cnt_q   <= cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word    <= '0;
            ready   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (done) word <= {shreg_q, sdi_s};
            ready   <= done | (ready & ~rd);
            overrun <= (done & ready & ~rd) | (overrun & ~rd);
        end
    end
endmodule

// File: rtl/fsp_port.sv
module fsp_port
    import fsp_pkg::*;
#(
    parameter int W = FSP_WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_we,
    input  logic [1:0]   ctl_wdata,
    output logic [2:0]   ctl_rdata,
    input  logic         tx_load,
    input  logic [W-1:0] tx_data,
    output logic         tx_empty,
    input  logic         rx_read,
    output logic [W-1:0] rx_data,
    output logic         rx_ready,
    output logic         rx_overrun,
    input  logic         hiz_n,
    input  logic         tclk_in,
    output logic         tclk_out,
    output logic         tclk_oe,
    input  logic         tfs_in,
    output logic         tfs_out,
    output logic         tfs_oe,
    output logic         sdo,
    output logic         sdo_oe,
    input  logic         rclk_in,
    input  logic         rfs_in,
    input  logic         sdi
);
    fsp_ctrl_t        ctrl_q;
    logic [PIN_N-1:0] pin_raw, pin_s;

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= '0;
        else if (ctl_we) ctrl_q <= fsp_ctrl_t'(ctl_wdata);
    end

    always_comb begin
        pin_raw           = '0;
        pin_raw[PIN_TCLK] = tclk_in;
        pin_raw[PIN_TFS]  = tfs_in;
        pin_raw[PIN_RCLK] = rclk_in;
        pin_raw[PIN_RFS]  = rfs_in;
        pin_raw[PIN_SDI]  = sdi;
    end

    fsp_sync #(.W(PIN_N), .RST_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    fsp_tx #(.W(W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .xclk_s    (pin_s[PIN_TCLK]),
        .xfs_s     (pin_s[PIN_TFS]),
        .load      (tx_load),
        .load_data (tx_data),
        .empty     (tx_empty),
        .bclk_gen  (tclk_out),
        .fs_gen    (tfs_out),
        .sdo       (sdo)
    );

    fsp_rx #(.W(W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rclk_s  (pin_s[PIN_RCLK]),
        .rfs_s   (pin_s[PIN_RFS]),
        .sdi_s   (pin_s[PIN_SDI]),
        .rd      (rx_read),
        .word    (rx_data),
        .ready   (rx_ready),
        .overrun (rx_overrun)
    );

    assign ctl_rdata = {pin_s[PIN_RCLK], ctrl_q.fs_master, ctrl_q.clk_master};
    assign tclk_oe   = hiz_n & ctrl_q.clk_master;
    assign tfs_oe    = hiz_n & ctrl_q.fs_master;
    assign sdo_oe    = hiz_n;
endmodule

// File: rtl/fsp_port_chk.sv
module fsp_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       hiz_n,
    input logic [2:0] ctl_rdata,
    input logic       tclk_out,
    input logic       tclk_oe,
    input logic       tfs_out,
    input logic       tfs_oe,
    input logic       sdo_oe,
    input logic       tx_load,
    input logic       tx_empty,
    input logic       rx_read,
    input logic       rx_ready,
    input logic       rx_overrun
);
    a_r9_all_tristate: assert property (@(posedge clk) disable iff (rst)
        !hiz_n |-> !(sdo_oe || tclk_oe || tfs_oe));

    a_r3_clock_toggles: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[0] |=> (tclk_out != $past(tclk_out)));

    a_r4_pulse_one_bit: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata[1:0] == 2'b11 && $fell(tfs_out)) |=> (!tfs_out ##1 tfs_out));

    a_r10_load_fills: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_empty);

    a_r7_overrun_needs_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> $past(rx_ready));

    a_r7_overrun_implies_ready: assert property (@(posedge clk) disable iff (rst)
        rx_overrun |-> rx_ready);

    a_r8_read_clears_overrun: assert property (@(posedge clk) disable iff (rst)
        rx_read |=> !rx_overrun);

    a_r6_ready_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rx_read) |=> rx_ready);
endmodule

bind fsp_port fsp_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .hiz_n      (hiz_n),
    .ctl_rdata  (ctl_rdata),
    .tclk_out   (tclk_out),
    .tclk_oe    (tclk_oe),
    .tfs_out    (tfs_out),
    .tfs_oe     (tfs_oe),
    .sdo_oe     (sdo_oe),
    .tx_load    (tx_load),
    .tx_empty   (tx_empty),
    .rx_read    (rx_read),
    .rx_ready   (rx_ready),
    .rx_overrun (rx_overrun)
);

// File: tb/fsp_port_bench.sv
`timescale 1ns/1ps
module fsp_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_wdata = '0;
    logic [2:0]  ctl_rdata;
    logic        tx_load = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_empty;
    logic        rx_read = 1'b0;
    logic [15:0] rx_data;
    logic        rx_ready, rx_overrun;
    logic        hiz_n = 1'b1;
    logic        b_xclk = 1'b0, b_xfs = 1'b1;
    logic        b_rclk = 1'b0, b_rfs = 1'b1, b_rdat = 1'b0;
    logic        lb = 1'b0;
    logic        tclk_out, tclk_oe, tfs_out, tfs_oe, sdo, sdo_oe;
    logic        rclk_in, rfs_in, sdi;

    int n_cmp = 0;
    int n_bad = 0;
    int fs_run = 0;
    int fs_len = 0;

    always #5 clk = ~clk;

    assign rclk_in = lb ? tclk_out : b_rclk;
    assign rfs_in  = lb ? tfs_out  : b_rfs;
    assign sdi     = lb ? sdo      : b_rdat;

    fsp_port u_fsp_port (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .tx_load(tx_load), .tx_data(tx_data),
        .tx_empty(tx_empty), .rx_read(rx_read), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_overrun(rx_overrun), .hiz_n(hiz_n),
        .tclk_in(b_xclk), .tclk_out(tclk_out), .tclk_oe(tclk_oe),
        .tfs_in(b_xfs), .tfs_out(tfs_out), .tfs_oe(tfs_oe),
        .sdo(sdo), .sdo_oe(sdo_oe), .rclk_in(rclk_in), .rfs_in(rfs_in),
        .sdi(sdi)
    );

    // length of each low pulse on the generated frame sync
    always @(negedge clk) begin
        if (!tfs_out) fs_run++;
        else if (fs_run != 0) begin fs_len = fs_run; fs_run = 0; end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ctl_write(input logic [1:0] v);
        ctl_wdata = v; ctl_we = 1'b1;
        wcyc(1);
        ctl_we = 1'b0;
    endtask

    task automatic rx_pulse_read();
        rx_read = 1'b1;
        wcyc(1);
        rx_read = 1'b0;
    endtask

    // external transmitter feeding the receive pins, 10-cycle bit period
    task automatic rx_frame(input logic [15:0] w);
        for (int i = 0; i < 16; i++) begin
            b_rclk = 1'b1; b_rdat = w[15-i]; b_rfs = (i == 0) ? 1'b0 : 1'b1;
            wcyc(5);
            b_rclk = 1'b0;
            wcyc(5);
        end
        wcyc(4);
    endtask

    // external clock and frame for the transmitter, sampling sdo at each fall
    task automatic tx_frame(input logic [15:0] exp, input string req);
        logic [15:0] got;
        got = '0;
        for (int i = 0; i < 16; i++) begin
            b_xclk = 1'b1; b_xfs = (i == 0) ? 1'b0 : 1'b1;
            wcyc(5);
            got[15-i] = sdo;
            b_xclk = 1'b0;
            wcyc(5);
        end
        b_xfs = 1'b1; b_xclk = 1'b1; wcyc(5);
        b_xclk = 1'b0; wcyc(5);
        chk(got == exp, req, {16'h0, got}, {16'h0, exp});
    endtask

    task automatic lb_word(input logic [15:0] w);
        int guard;
        fs_len = 0;
        tx_data = w; tx_load = 1'b1;
        wcyc(1);
        tx_load = 1'b0;
        chk(tx_empty == 1'b0, "R10 load fills holding", {31'h0, tx_empty}, 32'h0);
        guard = 0;
        while (!rx_ready && guard < 300) begin wcyc(1); guard++; end
        chk(rx_ready == 1'b1, "R6 loopback ready", {31'h0, rx_ready}, 32'h1);
        chk(rx_data == w, "R5 R6 loopback word", {16'h0, rx_data}, {16'h0, w});
        wcyc(4);
        chk(fs_len == 2, "R4 frame pulse width", fs_len, 32'd2);
        rx_pulse_read();
        chk(rx_ready == 1'b0, "R8 read clears ready", {31'h0, rx_ready}, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        wcyc(3);
        rst = 1'b0;
        wcyc(1);

        // R1 reset state
        chk(ctl_rdata[1:0] == 2'b00, "R1 ctrl", {29'h0, ctl_rdata}, 32'h0);
        chk(!tclk_oe && !tfs_oe, "R1 oe", {30'h0, tclk_oe, tfs_oe}, 32'h0);
        chk(tfs_out == 1'b1, "R1 frame idle", {31'h0, tfs_out}, 32'h1);
        chk(tx_empty == 1'b1, "R1 tx_empty", {31'h0, tx_empty}, 32'h1);
        chk(!rx_ready && !rx_overrun, "R1 rx flags", {30'h0, rx_ready, rx_overrun}, 32'h0);

        // R2 control register and receive clock level
        for (int v = 0; v < 4; v++) begin
            ctl_write(v[1:0]);
            chk(ctl_rdata[1:0] == v[1:0], "R2 ctrl readback", {30'h0, ctl_rdata[1:0]}, v);
        end
        ctl_write(2'b00);
        b_rclk = 1'b1; wcyc(3);
        chk(ctl_rdata[2] == 1'b1, "R2 rclk level high", {31'h0, ctl_rdata[2]}, 32'h1);
        b_rclk = 1'b0; wcyc(3);
        chk(ctl_rdata[2] == 1'b0, "R2 rclk level low", {31'h0, ctl_rdata[2]}, 32'h0);

        // R11 unframed clock edges are ignored
        for (int i = 0; i < 20; i++) begin
            b_rclk = 1'b1; b_rdat = i[0]; wcyc(5);
            b_rclk = 1'b0; wcyc(5);
        end
        chk(rx_ready == 1'b0, "R11 no word without frame", {31'h0, rx_ready}, 32'h0);
        rx_frame(16'h1234);
        chk(rx_data == 16'h1234, "R11 next word intact", {16'h0, rx_data}, 32'h1234);
        rx_pulse_read();

        // R6 receive sweep: walking ones, extremes, arithmetic pattern
        for (int k = 0; k < 24; k++) begin
            if (k < 16)       w = 16'h1 << k;
            else if (k == 16) w = 16'h0000;
            else if (k == 17) w = 16'hFFFF;
            else              w = 16'(k * 16'h3C5B);
            rx_frame(w);
            chk(rx_ready == 1'b1, "R6 ready", {31'h0, rx_ready}, 32'h1);
            chk(rx_data == w, "R6 word", {16'h0, rx_data}, {16'h0, w});
            rx_pulse_read();
            chk(rx_ready == 1'b0, "R8 ready cleared", {31'h0, rx_ready}, 32'h0);
        end

        // R7 overrun, R8 read clears it
        rx_frame(16'hA5A5);
        rx_frame(16'h5A5A);
        chk(rx_overrun == 1'b1, "R7 overrun set", {31'h0, rx_overrun}, 32'h1);
        chk(rx_data == 16'h5A5A, "R7 newer word kept", {16'h0, rx_data}, 32'h5A5A);
        rx_pulse_read();
        chk(!rx_ready && !rx_overrun, "R8 read clears both", {30'h0, rx_ready, rx_overrun}, 32'h0);

        // R5 slave transmit, R10 holding register behaviour
        for (int k = 0; k < 6; k++) begin
            w = 16'(16'h8001 + k * 16'h2469);
            tx_data = w; tx_load = 1'b1; wcyc(1); tx_load = 1'b0;
            chk(tx_empty == 1'b0, "R10 not empty after load", {31'h0, tx_empty}, 32'h0);
            tx_frame(w, "R5 slave transmit word");
            chk(tx_empty == 1'b1, "R10 empty after start", {31'h0, tx_empty}, 32'h1);
        end
        tx_frame(w, "R10 resend last word");

        // master clock and frame, looped back into the receiver
        ctl_write(2'b11);
        lb = 1'b1;
        wcyc(10);
        chk(tfs_out == 1'b1, "R4 no pulse without word", {31'h0, tfs_out}, 32'h1);
        chk(tclk_oe && tfs_oe, "R3 outputs enabled", {30'h0, tclk_oe, tfs_oe}, 32'h3);
        for (int i = 0; i < 6; i++) begin
            logic prev;
            prev = tclk_out;
            wcyc(1);
            chk(tclk_out != prev, "R3 half-rate toggle", {31'h0, tclk_out}, {31'h0, ~prev});
        end
        for (int k = 0; k < 20; k++) begin
            if (k < 16)       w = ~(16'h1 << k);
            else if (k == 16) w = 16'hFFFF;
            else if (k == 17) w = 16'h0001;
            else              w = 16'(k * 16'h1357);
            lb_word(w);
        end

        // R9 global output disable
        hiz_n = 1'b0; wcyc(1);
        chk(!sdo_oe && !tclk_oe && !tfs_oe, "R9 all tristate",
            {29'h0, sdo_oe, tclk_oe, tfs_oe}, 32'h0);
        hiz_n = 1'b1; wcyc(1);
        chk(sdo_oe && tclk_oe && tfs_oe, "R9 re-enabled",
            {29'h0, sdo_oe, tclk_oe, tfs_oe}, 32'h7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule